// File: doc/BRIEF.md
# Sleep and Wake-up Controller

This block sequences power-down and wake-up for a small microcontroller core. A one-cycle sleep strobe from the core stops the core clock enable. It also records the power-down and time-out status bits and sends a clear to the watchdog, which keeps counting while the core sleeps. Three kinds of event end the sleep.

- An external reset request restarts the device.
- A watchdog time-out resumes execution in line.
- An interrupt source whose own flag and enable are both set resumes execution.

The global interrupt enable does not decide whether the core wakes. It decides only what happens after the wake:
- When it is clear, execution goes on in line.
- When it is set, the instruction that follows the sleep retires first. Then a one-cycle branch request to the interrupt vector (0004h) is raised, followed by two dummy cycles.

If an enabled flag is already pending when the sleep strobe arrives, the sleep still completes and updates the status, but the core never stops. In crystal oscillator mode a wake holds the core stopped for an oscillator start-up count before it runs again. A watchdog time-out while the core is awake asks for a reset and clears the time-out bit.

Every pin is a plain control or status level or strobe. The block carries no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `slp_wake_ctrl`

## Requirements
- R1: After power-on reset (rst_n low), core_run_o=1, pd_o=1, to_o=1, and rst_req_o, wdt_clr_o, vec_req_o and dummy_o are all 0.
- R2: A sleep_i strobe while running, with no enabled flag pending and no reset or watchdog event, sets core_run_o=0, pd_o=0 and to_o=1 on the next cycle, and raises wdt_clr_o for exactly that one cycle.
- R3: ext_rst_i sampled high in any state raises rst_req_o on the next cycle. On that cycle core_run_o=1, no start-up count runs, and to_o and pd_o keep their values.
- R4: While asleep, wdt_tmo_i with wdt_en_i=1 wakes the core. On the next cycle to_o=0 and rst_req_o=0, and no vector request follows. With wdt_en_i=0 the time-out strobe leaves the core asleep.
- R5: An interrupt wakes the core only when irq_flag_i[i] and irq_en_i[i] are both 1 for the same index i. A flag without its enable leaves core_run_o at 0, whatever gie_i is.
- R6: After an interrupt wake with gie_i=0, vec_req_o stays 0, including after retire_i.
- R7: After an interrupt wake with gie_i=1, vec_req_o is 0 until retire_i is sampled. In the cycle after that sample, vec_req_o=1 for one cycle. It is followed by exactly two cycles of dummy_o=1, after which dummy_o returns to 0.
- R8: A sleep_i strobe while an enabled flag is pending leaves core_run_o=1. It still sets pd_o=0 and to_o=1 and pulses wdt_clr_o. With gie_i=1 the vector sequence of R7 follows.
- R9: Every wake from sleep pulses wdt_clr_o for one cycle, on the cycle after the wake event, whatever the source.
- R10: With xtal_mode_i=1, core_run_o stays 0 for exactly OST_CYCLES (default 1024) cycles, counted from the cycle after the wake event. With xtal_mode_i=0, core_run_o is 1 on the cycle after the wake event.
- R11: A watchdog time-out while awake (wdt_en_i=1) raises rst_req_o for one cycle and sets to_o=0. pd_o keeps its value and core_run_o stays 1.
- R12: A watchdog time-out and an enabled interrupt in the same sleeping cycle form one wake: to_o=0, and the vector sequence follows if gie_i=1. If an external reset comes with a watchdog time-out, the reset wins and to_o is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Power-on reset, active low |
| sleep_i | input | 1 | Sleep instruction executed (one-cycle strobe) |
| retire_i | input | 1 | Instruction after sleep has retired (strobe) |
| ext_rst_i | input | 1 | External reset request |
| wdt_en_i | input | 1 | Watchdog enabled |
| wdt_tmo_i | input | 1 | Watchdog time-out strobe |
| irq_flag_i | input | N_IRQ | Interrupt flags |
| irq_en_i | input | N_IRQ | Per-source interrupt enables |
| gie_i | input | 1 | Global interrupt enable |
| xtal_mode_i | input | 1 | Crystal oscillator mode (start-up count on wake) |
| core_run_o | output | 1 | Core clock enable |
| rst_req_o | output | 1 | Device reset request |
| wdt_clr_o | output | 1 | Watchdog clear pulse |
| vec_req_o | output | 1 | Branch to 0004h request (one cycle) |
| dummy_o | output | 1 | Dummy cycle before vector fetch |
| to_o | output | 1 | Time-out status bit |
| pd_o | output | 1 | Power-down status bit |

## Verification
A watchdog time-out and an enabled interrupt can reach the sleeping block in the same cycle. The bench drives both strobes on one edge with the global enable set. It then expects a single wake with the time-out bit cleared, no reset, and a full vector sequence once the following instruction retires. The bench also drives an external reset in the same cycle as a watchdog time-out during sleep. There it expects the reset request and an unchanged time-out bit, which shows that the reset takes priority.

// File: rtl/slp_pkg.sv
package slp_pkg;

  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_SLEEP   = 3'd1,
    ST_OST     = 3'd2,
    ST_WAITRET = 3'd3,
    ST_VEC     = 3'd4,
    ST_DUMMY   = 3'd5
  } slp_state_e;

  function automatic logic is_awake(input slp_state_e s);
    return (s != ST_SLEEP) && (s != ST_OST);
  endfunction

endpackage

// File: rtl/slp_irq_pend.sv
module slp_irq_pend #(
  parameter int N_IRQ = 3
) (
  input  logic [N_IRQ-1:0] flag_i,
  input  logic [N_IRQ-1:0] en_i,
  output logic             pend_o
);

  logic [N_IRQ-1:0] hit;

  // each source counts only when its own enable is set; the global enable is not used here
  for (genvar i = 0; i < N_IRQ; i++) begin : g_src
    assign hit[i] = flag_i[i] & en_i[i];
  end

  assign pend_o = |hit;

endmodule

// File: rtl/slp_ost_timer.sv
module slp_ost_timer #(
  parameter int OST_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic abort_i,
  output logic done_o
);

  localparam int CW = (OST_CYCLES > 1) ? $clog2(OST_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(OST_CYCLES - 1);

  logic          run_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (abort_i) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_i) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (run_q) begin
      if (cnt_q == LAST) begin
        run_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign done_o = run_q && (cnt_q == LAST);

  // R10: once started, the count runs without stopping until done or aborted
  a_r10_ost_continues: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !done_o && !abort_i && !start_i) |=> run_q);

endmodule

// File: rtl/slp_status.sv
module slp_status (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_pd_i,
  input  logic set_to_i,
  input  logic clr_to_i,
  output logic to_o,
  output logic pd_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_o <= 1'b1;
      to_o <= 1'b1;
    end else begin
      if (clr_pd_i) pd_o <= 1'b0;
      if (clr_to_i)      to_o <= 1'b0;
      else if (set_to_i) to_o <= 1'b1;
    end
  end

endmodule

// File: rtl/slp_wake_ctrl.sv
module slp_wake_ctrl
  import slp_pkg::*;
#(
  parameter int N_IRQ        = 3,
  parameter int OST_CYCLES   = 1024,
  parameter int DUMMY_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sleep_i,
  input  logic             retire_i,
  input  logic             ext_rst_i,
  input  logic             wdt_en_i,
  input  logic             wdt_tmo_i,
  input  logic [N_IRQ-1:0] irq_flag_i,
  input  logic [N_IRQ-1:0] irq_en_i,
  input  logic             gie_i,
  input  logic             xtal_mode_i,
  output logic             core_run_o,
  output logic             rst_req_o,
  output logic             wdt_clr_o,
  output logic             vec_req_o,
  output logic             dummy_o,
  output logic             to_o,
  output logic             pd_o
);

  localparam int DW = (DUMMY_CYCLES > 1) ? $clog2(DUMMY_CYCLES) : 1;
  localparam logic [DW-1:0] D_LAST = DW'(DUMMY_CYCLES - 1);

  slp_state_e state_q, state_d;
  logic       pend;
  logic       wdt_fire;
  logic       awake;
  logic       ost_start, ost_abort, ost_done;
  logic       clr_pd, set_to, clr_to;
  logic       rst_req_d, wdt_clr_d;
  logic       vec_q, vec_d;
  logic [DW-1:0] dcnt_q, dcnt_d;

  assign wdt_fire = wdt_tmo_i & wdt_en_i;
  assign awake    = is_awake(state_q);

  slp_irq_pend #(.N_IRQ(N_IRQ)) u_pend (
    .flag_i (irq_flag_i),
    .en_i   (irq_en_i),
    .pend_o (pend)
  );

  slp_ost_timer #(.OST_CYCLES(OST_CYCLES)) u_ost (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (ost_start),
    .abort_i (ost_abort),
    .done_o  (ost_done)
  );

  slp_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_pd_i (clr_pd),
    .set_to_i (set_to),
    .clr_to_i (clr_to),
    .to_o     (to_o),
    .pd_o     (pd_o)
  );

  // priority: external reset, then watchdog, then sleep / interrupt
  always_comb begin
    state_d   = state_q;
    clr_pd    = 1'b0;
    set_to    = 1'b0;
    clr_to    = 1'b0;
    rst_req_d = 1'b0;
    wdt_clr_d = 1'b0;
    ost_start = 1'b0;
    ost_abort = 1'b0;
    vec_d     = vec_q;
    dcnt_d    = dcnt_q;

    if (ext_rst_i) begin
      state_d   = ST_RUN;
      rst_req_d = 1'b1;
      wdt_clr_d = !awake;
      ost_abort = 1'b1;
      vec_d     = 1'b0;
      dcnt_d    = '0;
    end else if (awake && wdt_fire) begin
      state_d   = ST_RUN;
      rst_req_d = 1'b1;
      clr_to    = 1'b1;
      vec_d     = 1'b0;
      dcnt_d    = '0;
    end else begin
      unique case (state_q)
        ST_RUN: begin
          if (sleep_i) begin
            clr_pd    = 1'b1;
            set_to    = 1'b1;
            wdt_clr_d = 1'b1;
            if (pend) begin
              // sleep completes but the core never stops
              vec_d   = gie_i;
              state_d = gie_i ? ST_WAITRET : ST_RUN;
            end else begin
              state_d = ST_SLEEP;
            end
          end
        end
        ST_SLEEP: begin
          if (wdt_fire || pend) begin
            wdt_clr_d = 1'b1;
            clr_to    = wdt_fire;
            vec_d     = pend & gie_i;
            if (xtal_mode_i) begin
              ost_start = 1'b1;
              state_d   = ST_OST;
            end else begin
              state_d = (pend & gie_i) ? ST_WAITRET : ST_RUN;
            end
          end
        end
        ST_OST: begin
          if (ost_done) state_d = vec_q ? ST_WAITRET : ST_RUN;
        end
        ST_WAITRET: begin
          if (retire_i) state_d = ST_VEC;
        end
        ST_VEC: begin
          vec_d   = 1'b0;
          dcnt_d  = '0;
          state_d = ST_DUMMY;
        end
        ST_DUMMY: begin
          if (dcnt_q == D_LAST) begin
            dcnt_d  = '0;
            state_d = ST_RUN;
          end else begin
            dcnt_d = dcnt_q + 1'b1;
          end
        end
        default: state_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_RUN;
      vec_q     <= 1'b0;
      dcnt_q    <= '0;
      rst_req_o <= 1'b0;
      wdt_clr_o <= 1'b0;
    end else begin
      state_q   <= state_d;
      vec_q     <= vec_d;
      dcnt_q    <= dcnt_d;
      rst_req_o <= rst_req_d;
      wdt_clr_o <= wdt_clr_d;
    end
  end

  assign core_run_o = awake;
  assign vec_req_o  = (state_q == ST_VEC);
  assign dummy_o    = (state_q == ST_DUMMY);

  // R2: entering sleep records status and clears the watchdog
  a_r2_sleep_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && sleep_i && !ext_rst_i && !wdt_fire)
      |=> (!pd_o && to_o && wdt_clr_o));

  // R3: an external reset always yields a reset request with the core running
  a_r3_ext_reset: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rst_i |=> (rst_req_o && core_run_o));

  // R4: a watchdog wake continues in line and clears the time-out bit
  a_r4_wdt_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLEEP && wdt_fire && !ext_rst_i)
      |=> (!to_o && wdt_clr_o && !rst_req_o));

  // R7: the vector request lasts one cycle and dummy cycles follow
  a_r7_vec_single: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_req_o && !ext_rst_i && !wdt_fire) |=> (!vec_req_o && dummy_o));

  // R11: an awake time-out resets without touching the power-down bit
  a_r11_awake_wdt: assert property (@(posedge clk) disable iff (!rst_n)
    (awake && wdt_fire && !ext_rst_i) |=> (rst_req_o && !to_o && $stable(pd_o)));

endmodule

// File: tb/slp_wake_ctrl_bench.sv
module slp_wake_ctrl_bench;

  localparam int N_IRQ = 3;
  localparam int OST   = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_i = 1'b0, retire_i = 1'b0, ext_rst_i = 1'b0;
  logic wdt_en_i = 1'b0, wdt_tmo_i = 1'b0, gie_i = 1'b0, xtal_mode_i = 1'b0;
  logic [N_IRQ-1:0] irq_flag_i = '0, irq_en_i = '0;
  logic core_run_o, rst_req_o, wdt_clr_o, vec_req_o, dummy_o, to_o, pd_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  slp_wake_ctrl #(.N_IRQ(N_IRQ), .OST_CYCLES(OST), .DUMMY_CYCLES(2)) u_slp_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .retire_i(retire_i),
    .ext_rst_i(ext_rst_i), .wdt_en_i(wdt_en_i), .wdt_tmo_i(wdt_tmo_i),
    .irq_flag_i(irq_flag_i), .irq_en_i(irq_en_i), .gie_i(gie_i),
    .xtal_mode_i(xtal_mode_i), .core_run_o(core_run_o), .rst_req_o(rst_req_o),
    .wdt_clr_o(wdt_clr_o), .vec_req_o(vec_req_o), .dummy_o(dummy_o),
    .to_o(to_o), .pd_o(pd_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  task automatic go_sleep();
    sleep_i = 1'b1; tick(); sleep_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 core_run", core_run_o, 1);
    chk("R1 pd", pd_o, 1);
    chk("R1 to", to_o, 1);
    chk("R1 rst_req", rst_req_o, 0);
    chk("R1 wdt_clr", wdt_clr_o, 0);
    chk("R1 vec_req", vec_req_o, 0);
    chk("R1 dummy", dummy_o, 0);
  endtask

  task automatic t_sleep_entry();
    go_sleep();
    chk("R2 core_run", core_run_o, 0);
    chk("R2 pd", pd_o, 0);
    chk("R2 to", to_o, 1);
    chk("R2 wdt_clr", wdt_clr_o, 1);
    tick();
    chk("R2 wdt_clr one cycle", wdt_clr_o, 0);
    chk("R2 still asleep", core_run_o, 0);
  endtask

  task automatic t_no_wake();
    // asleep from t_sleep_entry
    gie_i = 1'b1; irq_flag_i = 3'b010; irq_en_i = 3'b000;
    wdt_en_i = 1'b0; wdt_tmo_i = 1'b1;
    tick(); wdt_tmo_i = 1'b0;
    chk("R4 disabled watchdog ignored", core_run_o, 0);
    tick(); tick();
    chk("R5 flag without enable no wake", core_run_o, 0);
    chk("R5 no wdt_clr", wdt_clr_o, 0);
    irq_flag_i = '0; gie_i = 1'b0;
  endtask

  task automatic t_irq_gie0();
    irq_en_i = 3'b010; irq_flag_i = 3'b010; gie_i = 1'b0; xtal_mode_i = 1'b0;
    tick(); irq_flag_i = '0;
    chk("R10 no start-up count", core_run_o, 1);
    chk("R9 wdt_clr on irq wake", wdt_clr_o, 1);
    chk("R5 enabled flag wakes", rst_req_o, 0);
    retire_i = 1'b1; tick(); retire_i = 1'b0;
    chk("R6 no vector", vec_req_o, 0);
    tick();
    chk("R6 no vector later", vec_req_o, 0);
    chk("R6 no dummy", dummy_o, 0);
  endtask

  task automatic t_irq_gie1();
    go_sleep();
    irq_en_i = 3'b001; irq_flag_i = 3'b001; gie_i = 1'b1;
    tick(); irq_flag_i = '0;
    chk("R7 awake", core_run_o, 1);
    tick();
    chk("R7 no vector before retire", vec_req_o, 0);
    retire_i = 1'b1; tick(); retire_i = 1'b0;
    chk("R7 vector", vec_req_o, 1);
    chk("R7 no dummy yet", dummy_o, 0);
    tick();
    chk("R7 vector one cycle", vec_req_o, 0);
    chk("R7 dummy 1", dummy_o, 1);
    tick();
    chk("R7 dummy 2", dummy_o, 1);
    tick();
    chk("R7 dummy ends", dummy_o, 0);
    gie_i = 1'b0;
  endtask

  task automatic t_wdt_xtal();
    int low = 0;
    xtal_mode_i = 1'b1; wdt_en_i = 1'b1; irq_en_i = '0;
    go_sleep();
    wdt_tmo_i = 1'b1; tick(); wdt_tmo_i = 1'b0;
    chk("R4 to cleared", to_o, 0);
    chk("R4 no reset", rst_req_o, 0);
    chk("R9 wdt_clr on wdt wake", wdt_clr_o, 1);
    while (!core_run_o && low < 5000) begin
      low++;
      tick();
    end
    chk("R10 start-up cycles", low, OST);
    tick(); tick();
    chk("R4 no vector", vec_req_o, 0);
    xtal_mode_i = 1'b0;
  endtask

  task automatic t_pend_at_sleep();
    irq_en_i = 3'b100; irq_flag_i = 3'b100; gie_i = 1'b1;
    go_sleep();
    irq_flag_i = '0;
    chk("R8 core keeps running", core_run_o, 1);
    chk("R8 pd", pd_o, 0);
    chk("R8 to", to_o, 1);
    chk("R8 wdt_clr", wdt_clr_o, 1);
    retire_i = 1'b1; tick(); retire_i = 1'b0;
    chk("R8 vector", vec_req_o, 1);
    tick(); tick(); tick();
    gie_i = 1'b0;
  endtask

  task automatic t_ext_reset();
    go_sleep();
    ext_rst_i = 1'b1; tick(); ext_rst_i = 1'b0;
    chk("R3 rst_req", rst_req_o, 1);
    chk("R3 core_run", core_run_o, 1);
    chk("R3 pd kept", pd_o, 0);
    chk("R3 to kept", to_o, 1);
    tick();
    chk("R3 rst_req ends", rst_req_o, 0);
  endtask

  task automatic t_awake_wdt();
    wdt_en_i = 1'b1; wdt_tmo_i = 1'b1; tick(); wdt_tmo_i = 1'b0;
    chk("R11 rst_req", rst_req_o, 1);
    chk("R11 to", to_o, 0);
    chk("R11 pd kept", pd_o, 0);
    chk("R11 core_run", core_run_o, 1);
    tick();
    chk("R11 rst_req one cycle", rst_req_o, 0);
  endtask

  task automatic t_concurrent();
    gie_i = 1'b1; irq_en_i = 3'b100; xtal_mode_i = 1'b0;
    go_sleep();
    wdt_tmo_i = 1'b1; irq_flag_i = 3'b100; tick();
    wdt_tmo_i = 1'b0; irq_flag_i = '0;
    chk("R12 to cleared", to_o, 0);
    chk("R12 awake", core_run_o, 1);
    chk("R12 no reset", rst_req_o, 0);
    retire_i = 1'b1; tick(); retire_i = 1'b0;
    chk("R12 vector", vec_req_o, 1);
    tick(); tick(); tick();
    go_sleep();
    ext_rst_i = 1'b1; wdt_tmo_i = 1'b1; tick();
    ext_rst_i = 1'b0; wdt_tmo_i = 1'b0;
    chk("R12 reset wins", rst_req_o, 1);
    chk("R12 to unchanged", to_o, 1);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_sleep_entry();
    t_no_wake();
    t_irq_gie0();
    t_irq_gie1();
    t_wdt_xtal();
    t_pend_at_sleep();
    t_ext_reset();
    t_awake_wdt();
    t_concurrent();
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

endmodule